// File: doc/BRIEF.md
# Burst SPI Master Controller

This block is a register-mapped SPI master. Software fills a 64-byte transmit queue, programs a 24-bit byte count and sets a self-clearing exchange bit. The engine then shifts that many bytes out, most significant bit first. It captures one received byte for every byte sent into a 64-byte receive queue, and clears the exchange bit once the burst has ended. Software polls that bit and then drains the receive queue.

Clock polarity and phase are set in the control register. One of four select lines is chosen, and it is driven either by the engine (asserted for the burst) or directly from a software-held level, with a programmable active polarity. The serial clock pace comes from an external enable pulse (`sck_tick`), one pulse per half period of the serial clock.

Top module: `spi_burst_master`

## Requirements
- R1: After reset every register reads zero and all select lines and `sclk` are low. Reading the control word at byte address 0x08 returns the fields last written. Writing a 32-bit value to 0x20 (byte count) or 0x24 (transmit count) reads back its low 24 bits.
- R2: Writing 1 to control bit 10 requests an exchange. The request starts a burst only while bit 0 (enable) and bit 1 (master) are both 1, and otherwise stays pending. Hardware clears bit 10 when the burst ends, and software cannot clear it.
- R3: A burst of N bytes sends N bytes on `mosi` MSB first, in the order they were written to 0x04. It pushes N received bytes into the receive queue, readable in order at 0x00, and produces exactly 16·N `sclk` transitions.
- R4: `sclk` idles at control bit 3 (CPOL). With bit 2 (CPHA) at 0, data is sampled on the first edge of each bit and changed on the second. With CPHA at 1, data is changed on the first edge and sampled on the second.
- R5: If the transmit queue runs empty before N bytes are sent, the missing bytes are sent as 0x00.
- R6: With control bit 16 at 0, only the line chosen by bits 13:12 is asserted. It is asserted from burst start until two `sck_tick` pulses after the last `sclk` edge.
- R7: With control bit 16 at 1, the chosen line is driven to the value of bit 17, and the other lines stay inactive.
- R8: Control bit 4 at 1 makes the select lines active-low (inactive level 1). At 0 they are active-high.
- R9: Writing 1 to control bit 8 empties the transmit queue, and writing 1 to bit 9 empties the receive queue. Each leaves the other queue unchanged.
- R10: A write to 0x04 while 64 bytes are queued is dropped. A read of 0x00 with the receive queue empty returns 0 and changes nothing.
- R11: Address 0x28 reports the receive fill count in bits 6:0 and the transmit fill count in bits 22:16.
- R12: An exchange with a byte count of 0 clears bit 10 without asserting any select line or moving `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at 0x00) |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| sck_tick | input | 1 | Half-period enable from the clock divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
A wrong bit counter or phase decode shows within one byte, as received bytes that do not match the slave's known pattern or sent bytes that the slave model captures misaligned. A queue pointer error shows at the next status read or data pop. A stuck state in the engine shows as an exchange bit that never clears, or as a select line whose release comes more or less than four system cycles after the last serial edge. The sweep covers all four clock modes against all four select lines and both polarities, so each phase error is seen in the first transfer of that mode.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 24,
  parameter int NCS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        sck_tick,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [NCS-1:0] cs_o
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = PW + 1;
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAIL} st_t;
  st_t st;

  logic en_q, mst_q, cpha_q, cpol_q, alow_q, xch_q, man_q, lvl_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] burst_q, xmit_q, rem_q;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [CW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic [7:0] osr, isr;
  logic [2:0] bcnt;
  logic       sclk_q, mosi_q, tcnt;

  logic unused_bits;
  assign unused_bits = ^wdata;

  assign tx_cnt = tx_wp - tx_rp;
  assign rx_cnt = rx_wp - rx_rp;

  wire wr_tx   = wr_en && addr == 6'h04;
  wire wr_ctl  = wr_en && addr == 6'h08;
  wire tx_full = tx_cnt == CW'(DEPTH);
  wire rx_full = rx_cnt == CW'(DEPTH);
  wire tx_rst  = wr_ctl && wdata[8];
  wire rx_rst  = wr_ctl && wdata[9];

  wire start    = st == S_IDLE && xch_q && en_q && mst_q;
  wire lead     = sclk_q == cpol_q;
  wire tick_x   = st == S_XFER && sck_tick;
  wire samp     = tick_x && (lead ^ cpha_q);
  wire shft     = tick_x && !(lead ^ cpha_q);
  wire byte_end = tick_x && !lead && bcnt == 3'd7;
  wire more     = rem_q > CNT_W'(1);
  wire load     = (start && burst_q != '0) || (byte_end && more);
  wire done     = (start && burst_q == '0) || (st == S_TAIL && sck_tick && tcnt);
  wire [7:0] bit_in = {isr[6:0], miso};
  wire [7:0] nxt    = (tx_cnt != '0) ? tx_mem[tx_rp[PW-1:0]] : 8'h00;

  wire tx_push = wr_tx && !tx_full;
  wire tx_pop  = load && tx_cnt != '0;
  wire rx_push = byte_end && !rx_full;
  wire rx_pop  = rd_en && addr == 6'h00 && rx_cnt != '0;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[PW-1:0]] <= wdata[7:0];
    if (rx_push) rx_mem[rx_wp[PW-1:0]] <= cpha_q ? bit_in : isr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_rst) begin
        tx_wp <= '0; tx_rp <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      end
      if (rx_rst) begin
        rx_wp <= '0; rx_rp <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, mst_q, cpha_q, cpol_q, alow_q, man_q, lvl_q} <= '0;
      sel_q   <= '0;
      burst_q <= '0;
      xmit_q  <= '0;
    end else begin
      if (wr_ctl) begin
        {cpol_q, cpha_q, mst_q, en_q} <= wdata[3:0];
        alow_q <= wdata[4];
        sel_q  <= wdata[12 +: SEL_W];
        man_q  <= wdata[16];
        lvl_q  <= wdata[17];
      end
      if (wr_en && addr == 6'h20) burst_q <= wdata[CNT_W-1:0];
      if (wr_en && addr == 6'h24) xmit_q  <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xch_q <= 1'b0;
    else if (done) xch_q <= 1'b0;
    else if (wr_ctl && wdata[10]) xch_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rem_q <= '0; bcnt <= '0; tcnt <= 1'b0;
      sclk_q <= 1'b0; mosi_q <= 1'b0; osr <= '0; isr <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          sclk_q <= cpol_q;
          if (start && burst_q != '0) begin
            st    <= S_XFER;
            rem_q <= burst_q;
            bcnt  <= '0;
          end
        end
        S_XFER: if (sck_tick) begin
          sclk_q <= ~sclk_q;
          if (!lead) bcnt <= bcnt + 1'b1;
          if (byte_end) begin
            rem_q <= rem_q - 1'b1;
            if (!more) begin
              st   <= S_TAIL;
              tcnt <= 1'b0;
            end
          end
        end
        S_TAIL: if (sck_tick) begin
          if (tcnt) st <= S_IDLE;
          tcnt <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (load) begin
        osr <= nxt;
        if (!cpha_q) mosi_q <= nxt[7];
      end else if (shft) begin
        mosi_q <= cpha_q ? osr[7] : osr[6];
        osr    <= {osr[6:0], 1'b0};
      end
      if (samp) isr <= bit_in;
    end
  end

  assign sclk = sclk_q;
  assign mosi = mosi_q;

  wire busy = st != S_IDLE;
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_o[g] = (sel_q == SEL_W'(g)) ? (man_q ? lvl_q : (busy ^ alow_q)) : alow_q;
  end

  logic [31:0] ctl_rd;
  always_comb begin
    ctl_rd = '0;
    ctl_rd[4:0] = {alow_q, cpol_q, cpha_q, mst_q, en_q};
    ctl_rd[10]  = xch_q;
    ctl_rd[12 +: SEL_W] = sel_q;
    ctl_rd[16]  = man_q;
    ctl_rd[17]  = lvl_q;
  end

  always_comb begin
    case (addr)
      6'h00:   rdata = (rx_cnt != '0) ? {24'h0, rx_mem[rx_rp[PW-1:0]]} : 32'h0;
      6'h08:   rdata = ctl_rd;
      6'h20:   rdata = 32'(burst_q);
      6'h24:   rdata = 32'(xmit_q);
      6'h28:   rdata = 32'(rx_cnt) | (32'(tx_cnt) << 16);
      default: rdata = 32'h0;
    endcase
  end

  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH)); // R10
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(DEPTH)); // R10
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n) st == S_IDLE |=> sclk == $past(cpol_q)); // R4
  AST_XCH_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(xch_q) |-> st == S_IDLE); // R2
  AST_CS_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_o ^ {NCS{alow_q}})); // R6
  AST_XFER_REM: assert property (@(posedge clk) disable iff (!rst_n) st == S_XFER |-> rem_q != '0); // R3
endmodule

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, sck_tick = 1'b0, miso = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi;
  logic [3:0] cs_o;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sck_tick(sck_tick), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int mon_sel = 0, mon_alow = 0, mon_cpha = 0;
  int n = 0, last_edge = 0, gap = 0, edges_rel = 0;
  logic last_sclk = 1'b0, was_act = 1'b0, bad_cs = 1'b0, cs_seen = 1'b0;
  logic [7:0] cap [0:127];

  function automatic logic [7:0] sl_byte(int k);
    return 8'(8'h5A ^ (k * 29));
  endfunction
  function automatic logic [7:0] tx_byte(int k, int m);
    return 8'(8'hC3 + k * 17 + m * 64);
  endfunction
  function automatic logic [31:0] cfg(int cpha, int cpol, int alow, int sel, int man, int lvl);
    return 32'h3 | (32'(cpha) << 2) | (32'(cpol) << 3) | (32'(alow) << 4) |
           (32'(sel) << 12) | (32'(man) << 16) | (32'(lvl) << 17);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) sck_tick <= 1'b0; else sck_tick <= ~sck_tick;
  end

  always @(negedge clk) begin
    logic act;
    int b;
    act = (cs_o[mon_sel] == (mon_alow == 0));
    if (act) begin
      cs_seen = 1'b1;
      if (sclk !== last_sclk) begin
        if ((mon_cpha != 0) == (n % 2 == 1)) begin
          b = n / 2;
          if (b / 8 < 128) cap[b / 8][7 - b % 8] = mosi;
        end
        n = n + 1;
        last_edge = cyc;
      end
    end else begin
      if (was_act) begin gap = cyc - last_edge; edges_rel = n; end
      n = 0;
    end
    if (((cs_o ^ {4{mon_alow[0]}}) & ~(4'b1 << mon_sel)) != 4'b0) bad_cs = 1'b1;
    was_act = act;
    last_sclk = sclk;
    b = (n == 0) ? 0 : ((mon_cpha != 0) ? (n - 1) / 2 : n / 2);
    miso = sl_byte(b / 8)[7 - b % 8];
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #2 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wait_done(output logic [31:0] c);
    c = 32'h400;
    for (int i = 0; i < 4000 && c[10]; i++) rd(6'h08, c);
  endtask

  task automatic run(input int nwr, input int burst, input int m, input int sel, input int alow);
    logic [31:0] d, c;
    int cpha, cpol;
    cpha = m % 2; cpol = m / 2;
    mon_sel = sel; mon_alow = alow; mon_cpha = cpha;
    wr(6'h08, cfg(cpha, cpol, alow, sel, 0, 0) | 32'h300);
    wr(6'h20, 32'(burst));
    for (int k = 0; k < nwr; k++) wr(6'h04, 32'(tx_byte(k, m)));
    repeat (4) @(negedge clk);
    bad_cs = 1'b0; edges_rel = -1; gap = -1;
    wr(6'h08, cfg(cpha, cpol, alow, sel, 0, 0) | 32'h400);
    wait_done(c);
    repeat (6) @(negedge clk);
    chk(c[10] == 1'b0, "R2 exchange bit self-clears", c, 32'h0);
    rd(6'h28, d);
    chk(d[6:0] == 7'(burst), "R3 rx fill equals burst (R11)", d, 32'(burst));
    chk(edges_rel == 16 * burst, "R3 sclk edge count", 32'(edges_rel), 32'(16 * burst));
    chk(gap == 4, "R6 select release two ticks after last edge", 32'(gap), 32'd4);
    chk(!bad_cs, "R6 only selected line asserted", {28'h0, cs_o}, 32'(sel));
    chk(sclk == cpol[0], "R4 sclk idles at CPOL", {31'h0, sclk}, 32'(cpol));
    chk(cs_o == {4{alow[0]}}, "R8 select lines at inactive level", {28'h0, cs_o}, {28'h0, {4{alow[0]}}});
    for (int k = 0; k < burst; k++) begin
      logic [7:0] e;
      rd(6'h00, d);
      chk(d == 32'(sl_byte(k)), "R4 received byte in mode (R3)", d, 32'(sl_byte(k)));
      e = (k < nwr) ? tx_byte(k, m) : 8'h00;
      chk(cap[k] == e, (k < nwr) ? "R3 sent byte MSB first (R4)" : "R5 underrun sends zero", 32'(cap[k]), 32'(e));
    end
  endtask

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(6'h08, d); chk(d == 0, "R1 control resets to zero", d, 0);
    rd(6'h28, d); chk(d == 0, "R1 status resets to zero (R11)", d, 0);
    rd(6'h20, d); chk(d == 0, "R1 count resets to zero", d, 0);
    chk(cs_o == 4'h0 && sclk == 1'b0, "R1 pins low after reset", {27'h0, sclk, cs_o}, 0);
    wr(6'h20, 32'hABCDEF12); rd(6'h20, d); chk(d == 32'h00CDEF12, "R1 byte count is 24 bits", d, 32'h00CDEF12);
    wr(6'h24, 32'h87654321); rd(6'h24, d); chk(d == 32'h00654321, "R1 transmit count is 24 bits", d, 32'h00654321);
    wr(6'h08, 32'h0003_3015); rd(6'h08, d); chk(d == 32'h0003_3015, "R1 control readback", d, 32'h0003_3015);

    // R7 manual select, R8 polarity
    wr(6'h08, cfg(0, 0, 1, 2, 1, 0)); @(negedge clk);
    chk(cs_o == 4'b1011, "R7 manual level 0 on line 2", {28'h0, cs_o}, 32'hB);
    wr(6'h08, cfg(0, 0, 1, 2, 1, 1)); @(negedge clk);
    chk(cs_o == 4'b1111, "R7 manual level 1 on line 2", {28'h0, cs_o}, 32'hF);
    wr(6'h08, cfg(0, 0, 0, 1, 1, 1)); @(negedge clk);
    chk(cs_o == 4'b0010, "R8 active-high manual line 1", {28'h0, cs_o}, 32'h2);

    // R4 R6 R8 R3 sweep over modes, lines, polarity
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        run(1 + (m + s) % 4, 1 + (m + s) % 4, m, s, s % 2);
    // R5 underrun
    run(2, 5, 1, 3, 1);
    run(0, 2, 2, 0, 0);

    // R10 R11 transmit full, R9 resets
    wr(6'h08, cfg(0, 0, 1, 0, 0, 0) | 32'h300);
    for (int k = 0; k < 66; k++) wr(6'h04, 32'(k));
    rd(6'h28, d); chk(d == 32'h0040_0000, "R10 tx full drops writes (R11)", d, 32'h0040_0000);
    rd(6'h00, d); chk(d == 0, "R10 empty read returns zero", d, 0);
    rd(6'h28, d); chk(d == 32'h0040_0000, "R10 empty read leaves status", d, 32'h0040_0000);
    wr(6'h08, cfg(0, 0, 1, 0, 0, 0) | 32'h100);
    rd(6'h28, d); chk(d == 0, "R9 tx reset empties tx", d, 0);

    // R12 zero-length burst
    mon_sel = 0; mon_alow = 1; mon_cpha = 0;
    wr(6'h20, 0); repeat (4) @(negedge clk); cs_seen = 1'b0;
    wr(6'h08, cfg(0, 0, 1, 0, 0, 0) | 32'h400);
    repeat (3) @(negedge clk);
    rd(6'h08, d); chk(d[10] == 1'b0, "R12 zero burst clears exchange", d, 0);
    chk(!cs_seen, "R12 zero burst keeps select idle", {31'h0, cs_seen}, 0);

    // R2 pending while disabled
    wr(6'h20, 2); wr(6'h04, 32'h11); wr(6'h04, 32'h22);
    repeat (4) @(negedge clk); cs_seen = 1'b0;
    wr(6'h08, (cfg(0, 0, 1, 0, 0, 0) & ~32'h1) | 32'h400);
    repeat (40) @(negedge clk);
    rd(6'h08, d); chk(d[10] == 1'b1, "R2 request pending while disabled", d, 32'h400);
    chk(!cs_seen, "R2 no burst while disabled", {31'h0, cs_seen}, 0);
    wr(6'h08, cfg(0, 0, 1, 0, 0, 0));
    wait_done(d);
    chk(d[10] == 1'b0, "R2 pending request runs once enabled", d, 0);
    repeat (6) @(negedge clk);
    chk(cap[0] == 8'h11 && cap[1] == 8'h22, "R3 bytes after enable", {16'h0, cap[0], cap[1]}, 32'h1122);

    // R9 rx reset keeps tx
    wr(6'h04, 32'h33); wr(6'h04, 32'h44); wr(6'h04, 32'h55);
    wr(6'h08, cfg(0, 0, 1, 0, 0, 0) | 32'h200);
    rd(6'h28, d); chk(d == 32'h0003_0000, "R9 rx reset keeps tx queue (R11)", d, 32'h0003_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule